// File: doc/BRIEF.md
# Register-File ALU with Three-Way Compare Flags

This block is a small execution unit. It holds a bank of general registers and a condition code register. When a start strobe arrives, the unit reads two source registers by index and places them on an internal operand bus. It then applies an arithmetic, logic or compare operation to them. Arithmetic and logic results go back into a destination register chosen by index. A compare does not write a register. Instead it records how the two sources relate, using three flags that exclude each other: greater, equal and less.

A separate load port fills the registers from outside. A combinational read port lets the surrounding logic see any register at any time. Each operation takes one clock: the result is in place, and a done strobe is high, in the cycle after start.

Top module: `flag_alu`

## Requirements
- R1: While reset (active low) is held, and in the first cycle after it, every register reads 0, the flags read equal (gtO=0, eqO=1, ltO=0) and doneO is 0.
- R2: With startI low and loadEnI high, register loadIdxI takes loadDataI at the clock edge. readDataO always shows the current content of register readIdxI, without delay.
- R3: Opcode 0 writes srcA+srcB into register dstI, and opcode 1 writes srcA-srcB. Both wrap modulo 256.
- R4: Opcode 2 writes srcA AND srcB, opcode 3 writes srcA OR srcB, and opcode 4 writes the bitwise NOT of srcA. For opcode 4 the second source has no effect.
- R5: Opcode 5 compares srcA with srcB as unsigned numbers. It sets exactly one flag: gtO if srcA>srcB, eqO if they are equal, ltO if srcA<srcB. It writes no register. At all times after reset, exactly one flag is high.
- R6: Opcodes 0 to 4 leave the three flags unchanged.
- R7: doneO is high in exactly the cycle that follows each cycle in which startI is high. Its result or flags are visible in that same cycle.
- R8: In a cycle where startI is high, the load port is ignored, and only the operation may change a register.
- R9: Opcodes 6 and 7 write no register and leave the flags unchanged, but still produce a done pulse.
- R10: The operands are the register values from before the operation. This holds when dstI equals a source, and when operations follow each other in back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low reset, synchronous |
| startI | input | 1 | Launches the operation selected by opI |
| opI | input | 3 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 not, 5 compare) |
| srcAI | input | 3 | Index of the first source register |
| srcBI | input | 3 | Index of the second source register |
| dstI | input | 3 | Index of the destination register |
| loadEnI | input | 1 | Writes loadDataI into register loadIdxI |
| loadIdxI | input | 3 | Register index for the load port |
| loadDataI | input | 8 | Data for the load port |
| readIdxI | input | 3 | Register index for the read port |
| readDataO | output | 8 | Content of register readIdxI |
| gtO | output | 1 | Last compare found srcA greater |
| eqO | output | 1 | Last compare found the operands equal |
| ltO | output | 1 | Last compare found srcA less |
| doneO | output | 1 | One-cycle pulse after each start |

## Verification
The hardest cases to reach are an operation that overwrites its own source, and a dependent operation issued in the very next cycle. Both need the register bank preloaded and the start strobe held high over successive cycles, so the bench drives chains of back-to-back operations that reuse destinations as sources. A load that arrives in the same cycle as a start must also be shown to have no effect. The bench does this by reading the load target after the operation. Unsigned comparison is checked with operands whose sign bits differ.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_NOT  = 3'd4,
    OP_CMP  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } aluOpE;

  // strobes from control to datapath
  typedef struct packed {
    logic  regWr;
    logic  ccrWr;
    logic  loadWr;
    aluOpE op;
  } ctrlS;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } ccrS;

endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startI,
  input  logic [2:0] opI,
  input  logic       loadEnI,
  output ctrlS       ctrlO,
  output logic       doneO
);

  aluOpE opDec;

  always_comb begin
    opDec        = aluOpE'(opI);
    ctrlO.op     = opDec;
    ctrlO.regWr  = 1'b0;
    ctrlO.ccrWr  = 1'b0;
    ctrlO.loadWr = loadEnI && !startI;
    if (startI) begin
      unique case (opDec)
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOT: ctrlO.regWr = 1'b1;
        OP_CMP:                                ctrlO.ccrWr = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneO <= 1'b0;
    else       doneO <= startI;
  end

endmodule

// File: rtl/flag_alu_dp.sv
module flag_alu_dp
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int REGS  = 8,
  localparam int IDXW = $clog2(REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlS             ctrlI,
  input  logic [IDXW-1:0]  srcAI,
  input  logic [IDXW-1:0]  srcBI,
  input  logic [IDXW-1:0]  dstI,
  input  logic [IDXW-1:0]  loadIdxI,
  input  logic [WIDTH-1:0] loadDataI,
  input  logic [IDXW-1:0]  readIdxI,
  output logic [WIDTH-1:0] readDataO,
  output ccrS              ccrO
);

  logic [WIDTH-1:0] regBank [REGS];
  logic [WIDTH-1:0] busA, busB, result;
  logic [REGS-1:0]  opWrEn, ldWrEn;
  ccrS              cmpFlags;

  // operand bus
  assign busA      = regBank[srcAI];
  assign busB      = regBank[srcBI];
  assign readDataO = regBank[readIdxI];

  always_comb begin
    unique case (ctrlI.op)
      OP_ADD:  result = busA + busB;
      OP_SUB:  result = busA - busB;
      OP_AND:  result = busA & busB;
      OP_OR:   result = busA | busB;
      OP_NOT:  result = ~busA;
      default: result = '0;
    endcase
  end

  always_comb begin
    cmpFlags.gt = busA > busB;
    cmpFlags.eq = busA == busB;
    cmpFlags.lt = busA < busB;
  end

  // per-register write decode
  for (genvar i = 0; i < REGS; i++) begin : g_wrDec
    localparam logic [IDXW-1:0] SLOT = IDXW'(i);
    assign opWrEn[i] = ctrlI.regWr  && (dstI == SLOT);
    assign ldWrEn[i] = ctrlI.loadWr && (loadIdxI == SLOT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REGS; i++) regBank[i] <= '0;
    end else begin
      for (int i = 0; i < REGS; i++) begin
        if (opWrEn[i])      regBank[i] <= result;
        else if (ldWrEn[i]) regBank[i] <= loadDataI;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            ccrO <= '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
    else if (ctrlI.ccrWr) ccrO <= cmpFlags;
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int REGS  = 8,
  localparam int IDXW = $clog2(REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startI,
  input  logic [2:0]       opI,
  input  logic [IDXW-1:0]  srcAI,
  input  logic [IDXW-1:0]  srcBI,
  input  logic [IDXW-1:0]  dstI,
  input  logic             loadEnI,
  input  logic [IDXW-1:0]  loadIdxI,
  input  logic [WIDTH-1:0] loadDataI,
  input  logic [IDXW-1:0]  readIdxI,
  output logic [WIDTH-1:0] readDataO,
  output logic             gtO,
  output logic             eqO,
  output logic             ltO,
  output logic             doneO
);

  ctrlS ctrl;
  ccrS  ccr;

  flag_alu_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .startI  (startI),
    .opI     (opI),
    .loadEnI (loadEnI),
    .ctrlO   (ctrl),
    .doneO   (doneO)
  );

  flag_alu_dp #(.WIDTH(WIDTH), .REGS(REGS)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlI     (ctrl),
    .srcAI     (srcAI),
    .srcBI     (srcBI),
    .dstI      (dstI),
    .loadIdxI  (loadIdxI),
    .loadDataI (loadDataI),
    .readIdxI  (readIdxI),
    .readDataO (readDataO),
    .ccrO      (ccr)
  );

  assign gtO = ccr.gt;
  assign eqO = ccr.eq;
  assign ltO = ccr.lt;

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            startI,
  input logic [2:0]      opI,
  input logic [IDXW-1:0] srcAI,
  input logic [IDXW-1:0] srcBI,
  input logic            gtO,
  input logic            eqO,
  input logic            ltO,
  input logic            doneO
);

  p_flags_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $countones({gtO, eqO, ltO}) == 1);

  p_same_src_equal_r5: assert property (@(posedge clk) disable iff (!rstN)
    (startI && opI == 3'd5 && srcAI == srcBI) |=> eqO);

  p_done_after_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    startI |=> doneO);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    !startI |=> !doneO);

  p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(startI && opI == 3'd5) |=> $stable({gtO, eqO, ltO}));

endmodule

bind flag_alu flag_alu_chk #(.IDXW(IDXW)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .startI (startI),
  .opI    (opI),
  .srcAI  (srcAI),
  .srcBI  (srcBI),
  .gtO    (gtO),
  .eqO    (eqO),
  .ltO    (ltO),
  .doneO  (doneO)
);

// File: tb/flag_alu_tb_top.sv
`timescale 1ns/1ps
module flag_alu_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       startI, loadEnI;
  logic [2:0] opI, srcAI, srcBI, dstI, loadIdxI, readIdxI;
  logic [7:0] loadDataI, readDataO;
  logic       gtO, eqO, ltO, doneO;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference state
  int mReg [8];
  int mFlags;   // {gt,eq,lt}
  int mDone;

  always #2.5 clk = ~clk;

  flag_alu dut_i (
    .clk(clk), .rstN(rstN), .startI(startI), .opI(opI),
    .srcAI(srcAI), .srcBI(srcBI), .dstI(dstI),
    .loadEnI(loadEnI), .loadIdxI(loadIdxI), .loadDataI(loadDataI),
    .readIdxI(readIdxI), .readDataO(readDataO),
    .gtO(gtO), .eqO(eqO), .ltO(ltO), .doneO(doneO)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 8; i++) mReg[i] = 0;
    mFlags = 3'b010;
    mDone  = 0;
  endtask

  task automatic modelEdge();
    int a, b;
    mDone = startI;
    if (!rstN) begin
      modelReset();
    end else if (startI) begin
      a = mReg[srcAI];
      b = mReg[srcBI];
      case (opI)
        3'd0: mReg[dstI] = (a + b) & 255;
        3'd1: mReg[dstI] = (a - b) & 255;
        3'd2: mReg[dstI] = a & b;
        3'd3: mReg[dstI] = a | b;
        3'd4: mReg[dstI] = (~a) & 255;
        3'd5: mFlags = (a > b) ? 3'b100 : (a == b) ? 3'b010 : 3'b001;
        default: ;
      endcase
    end else if (loadEnI) begin
      mReg[loadIdxI] = loadDataI;
    end
    if (!rstN) mDone = 0;
  endtask

  // one clock; inputs already driven; compare at following negedge
  task automatic tick(string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check({tag, " done"},  doneO, mDone);
    check({tag, " flags"}, {gtO, eqO, ltO}, mFlags);
    check({tag, " read"},  readDataO, mReg[readIdxI]);
  endtask

  task automatic idle();
    startI = 0; loadEnI = 0;
  endtask

  task automatic load(int idx, int val);
    idle();
    loadEnI = 1; loadIdxI = idx[2:0]; loadDataI = val[7:0]; readIdxI = idx[2:0];
    tick("R2 load");
  endtask

  task automatic op(string tag, int code, int a, int b, int d);
    idle();
    startI = 1; opI = code[2:0]; srcAI = a[2:0]; srcBI = b[2:0];
    dstI = d[2:0]; readIdxI = d[2:0];
    tick(tag);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 0; startI = 0; loadEnI = 0; opI = 0;
    srcAI = 0; srcBI = 0; dstI = 0; loadIdxI = 0; loadDataI = 0; readIdxI = 0;
    modelReset();
    repeat (3) tick("R1 in reset");
    rstN = 1;
    // R1: cleared bank and EQ flags right after reset
    for (int i = 0; i < 8; i++) begin
      idle(); readIdxI = i[2:0];
      tick("R1 after reset");
    end
    check("R1 eq flag", eqO, 1);

    // R2: fill the bank
    load(0, 8'hC8); load(1, 8'h64); load(2, 8'h05); load(3, 8'h0A);
    load(4, 8'hF0); load(5, 8'h3C); load(6, 8'hFF); load(7, 8'h01);
    idle(); readIdxI = 3'd4; #1;
    check("R2 comb read", readDataO, 8'hF0);

    // R3 wrap
    op("R3 add wrap", 0, 0, 1, 2);   // 200+100 -> 44
    check("R3 add value", readDataO, 44);
    load(2, 5);
    op("R3 sub wrap", 1, 2, 3, 2);   // 5-10 -> 251
    check("R3 sub value", readDataO, 251);

    // R4 logic; R6 flags hold
    op("R4 and", 2, 4, 5, 0);
    check("R4 and value", readDataO, 8'h30);
    op("R4 or", 3, 4, 5, 1);
    check("R4 or value", readDataO, 8'hFC);
    op("R4 not", 4, 5, 6, 2);
    check("R4 not value", readDataO, 8'hC3);
    check("R6 flags unchanged", {gtO, eqO, ltO}, 3'b010);

    // R5 unsigned compare
    op("R5 cmp gt", 5, 6, 7, 6);     // 255 vs 1 unsigned greater
    check("R5 gt", {gtO, eqO, ltO}, 3'b100);
    check("R5 no reg write", readDataO, 255);
    op("R5 cmp lt", 5, 7, 6, 0);
    check("R5 lt", {gtO, eqO, ltO}, 3'b001);
    op("R5 cmp eq", 5, 3, 3, 0);
    check("R5 eq", {gtO, eqO, ltO}, 3'b010);
    op("R6 after cmp", 0, 3, 3, 5);
    check("R6 flags held", {gtO, eqO, ltO}, 3'b010);

    // R8 load ignored during start
    idle();
    startI = 1; opI = 3'd0; srcAI = 3; srcBI = 3; dstI = 4; readIdxI = 4;
    loadEnI = 1; loadIdxI = 3'd7; loadDataI = 8'hAA;
    tick("R8 load+start");
    idle(); readIdxI = 3'd7; tick("R8 target");
    check("R8 load ignored", readDataO, 1);

    // R9 reserved opcodes
    op("R9 op6", 6, 0, 1, 0);
    op("R9 op7", 7, 0, 1, 1);
    check("R9 done pulses", doneO, 1);
    idle(); readIdxI = 0; tick("R9 dst0 kept");

    // R10 dst==src and back-to-back dependency; R7 done stays high
    load(1, 8'h81);
    op("R10 self add", 0, 1, 1, 1);  // 0x81+0x81 -> 0x02
    check("R10 self value", readDataO, 2);
    op("R10 chain", 0, 1, 1, 1);     // 4
    check("R7 back-to-back done", doneO, 1);
    op("R10 chain2", 1, 1, 7, 1);    // 3
    check("R10 chain value", readDataO, 3);
    idle(); readIdxI = 1; tick("R7 done drop");
    check("R7 done single", doneO, 0);

    // mixed stimulus, compared every clock
    for (int n = 0; n < 600; n++) begin
      startI    = ($urandom_range(0, 9) < 7);
      loadEnI   = $urandom_range(0, 1);
      opI       = 3'($urandom_range(0, 7));
      srcAI     = 3'($urandom_range(0, 7));
      srcBI     = 3'($urandom_range(0, 7));
      dstI      = 3'($urandom_range(0, 7));
      loadIdxI  = 3'($urandom_range(0, 7));
      loadDataI = 8'($urandom_range(0, 255));
      readIdxI  = startI ? dstI : 3'($urandom_range(0, 7));
      tick("R3 R4 R5 R6 R8 R10 mixed");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule